// File: doc/BRIEF.md
# Local Memory Page Protection Checker

This block sits in front of a banked local memory and rules on each access against permission attributes kept per page. A request carries an offset into the local memory window, the requester's privilege ID and several flags. The flags say whether the CPU issued the request directly or a DMA engine did, whether the CPU programmed that DMA, whether the mode is user or supervisor, whether the access is secure, and whether it is a read, a write or an instruction fetch. One clock later the block gives its verdict. Each memory port is split into 32 pages, so the page size follows the size of the port that serves the address. A 1MB port has 32KB pages and a 512KB port has 16KB pages.

There are 64 attribute registers, reached through a plain write/read port. Registers 0 to 31 belong to port 0 and registers 32 to 63 belong to port 1. A layout input selects one of two layouts. The symmetric layout has a single 1MB port 0. The asymmetric layout puts a 1MB port 1 at the start of the window and a 512KB port 0 after it, which swaps which register bank governs which part of the window. The first denied access is stored in a fault record, together with its address, privilege ID, access type, effective mode and secure flag. Software clears the record by writing to index 64.

The request stream has no back-pressure. A request is accepted in every cycle that `req_valid` is high. The verdict appears exactly one cycle later and cannot be stalled, so the consumer must take it in that cycle.

Top module: `l2_page_guard`

## Requirements
- R1: In the symmetric layout (`cfg_asym`=0), offsets below 0x100000 use register index offset[19:15]. All higher offsets are absent.
- R2: In the asymmetric layout, offsets below 0x100000 use register 32+offset[19:15]. Offsets from 0x100000 to 0x17FFFF use register (offset-0x100000)[18:14]. Offsets from 0x180000 upward are absent.
- R3: An access to an absent offset is always denied, whatever the attributes say.
- R4: Attribute bits 0/1/2 are user read/write/execute and bits 3/4/5 are supervisor read/write/execute. Only the bit selected by the access type (0 read, 1 write, 2 execute) and the effective mode is checked.
- R5: A CPU-initiated access (`req_local`=1) additionally needs bit 6 (local enable).
- R6: A DMA access (`req_local`=0) from privilege ID n, where n is 0 to 5, needs bit 7+n. Any other ID needs bit 13.
- R7: The effective mode is supervisor only when `req_sup`=1 and the request is local or CPU-programmed (`req_cpu`=1). All other masters are checked as user.
- R8: When `sec_en`=1, a non-secure access is denied unless bit 14 (open to non-secure) is set. When `sec_en`=0, the secure flag is ignored.
- R9: `res_valid` is high exactly one cycle after each `req_valid`. `fault_pulse` is high for that single cycle when the verdict is deny.
- R10: The first deny while the record is empty fills the fault record and sets `flt_valid`. Later denies leave the record unchanged.
- R11: A register write to index 64 empties the record. If a deny occurs in the same cycle as that write, the new deny is captured instead.
- R12: After reset every register reads 0x0078 (supervisor RWX and local enable set). A write is seen by `reg_rdata` at once and by requests from the next cycle on. A request in the same cycle as the write uses the old value.
- R13: Access type code 3 is always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_asym | input | 1 | 0 symmetric layout, 1 asymmetric layout |
| sec_en | input | 1 | Security enforcement enable |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 21 | Offset into the local memory window |
| req_pid | input | 4 | Requester privilege ID |
| req_local | input | 1 | 1 CPU-initiated, 0 DMA-initiated |
| req_cpu | input | 1 | DMA programmed by the CPU |
| req_sup | input | 1 | Supervisor mode of the issuing CPU |
| req_secure | input | 1 | Secure access |
| req_type | input | 2 | 0 read, 1 write, 2 execute, 3 invalid |
| res_valid | output | 1 | Verdict valid |
| res_allow | output | 1 | 1 allowed, 0 denied |
| fault_pulse | output | 1 | One-cycle pulse on deny |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register index (0..63 attributes, 64 record clear) |
| reg_wdata | input | 15 | Write data |
| reg_rdata | output | 15 | Attribute at `reg_addr` (0 when index is 64 or above) |
| flt_valid | output | 1 | Fault record holds a fault |
| flt_addr | output | 21 | Offset of the recorded fault |
| flt_pid | output | 4 | Privilege ID of the recorded fault |
| flt_type | output | 2 | Access type of the recorded fault |
| flt_sup | output | 1 | Effective mode of the recorded fault |
| flt_secure | output | 1 | Secure flag of the recorded fault |

## Verification
Two pairs of events can land on the same clock edge, and both are provoked on purpose. The first is an attribute write and a request to the page that the write changes. The second is a fault-record clear and a new deny. Directed cases set up both overlaps with known outcomes. The random phase writes registers and clears the record in the same cycles as requests, so both overlaps recur many times. A bench model that uses the pre-write attributes and lets capture win over clear judges every verdict and every field of the record.

// File: rtl/l2pg_pkg.sv
package l2pg_pkg;
  localparam int ATTR_W   = 15;
  localparam int B_UR     = 0;
  localparam int B_SR     = 3;
  localparam int B_LOC    = 6;
  localparam int B_AID0   = 7;
  localparam int NUM_AID  = 6;
  localparam int B_AIDX   = 13;
  localparam int B_NS     = 14;
  localparam logic [ATTR_W-1:0] ATTR_RST = 15'h0078;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_BAD = 2'd3
  } acc_t;
endpackage

// File: rtl/l2pg_page_map.sv
module l2pg_page_map #(
  parameter int ADDR_W   = 21,
  parameter int BIG_LG   = 20,
  parameter int SMALL_LG = 19,
  parameter int PG_LG    = 5,
  localparam int IDX_W   = PG_LG + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              asym,
  output logic              present,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] BIG_SIZE   = ADDR_W'(1) << BIG_LG;
  localparam logic [ADDR_W-1:0] SMALL_SIZE = ADDR_W'(1) << SMALL_LG;
  localparam logic [ADDR_W-1:0] BIG_PAGE   = ADDR_W'(1) << (BIG_LG - PG_LG);
  localparam logic [ADDR_W-1:0] SMALL_PAGE = ADDR_W'(1) << (SMALL_LG - PG_LG);

  logic              big_hit, small_hit;
  logic [ADDR_W-1:0] off2;
  logic [PG_LG-1:0]  big_pg, small_pg;

  always_comb begin
    big_hit   = addr < BIG_SIZE;
    off2      = addr - BIG_SIZE;
    small_hit = !big_hit && (off2 < SMALL_SIZE);
    big_pg    = PG_LG'(addr / BIG_PAGE);
    small_pg  = PG_LG'(off2 / SMALL_PAGE);
    present   = big_hit || (asym && small_hit);
    if (big_hit) idx = {asym, big_pg};
    else         idx = {1'b0, small_pg};
  end

  // R1
  always_comb begin
    if (!asym && present) begin
      sym_low_bank_chk: assert (idx[IDX_W-1] == 1'b0);
    end
  end
endmodule

// File: rtl/l2pg_perm_eval.sv
module l2pg_perm_eval
  import l2pg_pkg::*;
#(
  parameter int PID_W = 4
) (
  input  logic [ATTR_W-1:0] attr,
  input  acc_t              typ,
  input  logic              sup_eff,
  input  logic              is_local,
  input  logic [PID_W-1:0]  pid,
  input  logic              secure,
  input  logic              sec_en,
  output logic              ok
);
  logic rwx_ok, origin_ok, sec_ok, aid_ok;

  always_comb begin
    rwx_ok = 1'b0;
    case (typ)
      ACC_RD, ACC_WR, ACC_EX:
        rwx_ok = attr[(sup_eff ? B_SR : B_UR) + int'(typ)];
      default: rwx_ok = 1'b0;
    endcase

    aid_ok = attr[B_AIDX];
    for (int n = 0; n < NUM_AID; n++) begin
      if (pid == PID_W'(n)) aid_ok = attr[B_AID0 + n];
    end

    origin_ok = is_local ? attr[B_LOC] : aid_ok;
    sec_ok    = !sec_en || secure || attr[B_NS];
    ok        = rwx_ok && origin_ok && sec_ok;
  end

  // R13
  always_comb begin
    if (typ == ACC_BAD) begin
      bad_type_chk: assert (!ok);
    end
  end
endmodule

// File: rtl/l2pg_fault_rec.sv
module l2pg_fault_rec #(
  parameter int ADDR_W = 21,
  parameter int PID_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              clr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [PID_W-1:0]  in_pid,
  input  logic [1:0]        in_type,
  input  logic              in_sup,
  input  logic              in_secure,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [PID_W-1:0]  pid,
  output logic [1:0]        typ,
  output logic              sup,
  output logic              secure
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      addr   <= '0;
      pid    <= '0;
      typ    <= '0;
      sup    <= 1'b0;
      secure <= 1'b0;
    end else if (cap && (!valid || clr)) begin
      valid  <= 1'b1;
      addr   <= in_addr;
      pid    <= in_pid;
      typ    <= in_type;
      sup    <= in_sup;
      secure <= in_secure;
    end else if (clr) begin
      valid  <= 1'b0;
    end
  end

  // R10
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !clr) |=> (valid && $stable(addr) && $stable(pid) && $stable(typ)));

  // R10
  rec_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(cap));
endmodule

// File: rtl/l2_page_guard.sv
module l2_page_guard
  import l2pg_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int BIG_LG      = 20,
  parameter int SMALL_LG    = 19,
  parameter int PG_PER_PORT = 32,
  parameter int PID_W       = 4,
  localparam int PG_LG      = $clog2(PG_PER_PORT),
  localparam int NREG       = 2 * PG_PER_PORT,
  localparam int IDX_W      = PG_LG + 1,
  localparam int RA_W       = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_asym,
  input  logic              sec_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PID_W-1:0]  req_pid,
  input  logic              req_local,
  input  logic              req_cpu,
  input  logic              req_sup,
  input  logic              req_secure,
  input  logic [1:0]        req_type,
  output logic              res_valid,
  output logic              res_allow,
  output logic              fault_pulse,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [ATTR_W-1:0] reg_wdata,
  output logic [ATTR_W-1:0] reg_rdata,
  output logic              flt_valid,
  output logic [ADDR_W-1:0] flt_addr,
  output logic [PID_W-1:0]  flt_pid,
  output logic [1:0]        flt_type,
  output logic              flt_sup,
  output logic              flt_secure
);
  localparam logic [RA_W-1:0] CLR_IDX = RA_W'(NREG);

  logic [ATTR_W-1:0] attr_q [NREG];
  logic              pg_present;
  logic [IDX_W-1:0]  pg_idx;
  logic              perm_ok, allow_c, sup_eff, rec_clr;
  logic              rv_q, ra_q;

  assign sup_eff = req_sup && (req_local || req_cpu);
  assign rec_clr = reg_we && (reg_addr == CLR_IDX);

  l2pg_page_map #(
    .ADDR_W(ADDR_W), .BIG_LG(BIG_LG), .SMALL_LG(SMALL_LG), .PG_LG(PG_LG)
  ) map_i (
    .addr(req_addr), .asym(cfg_asym), .present(pg_present), .idx(pg_idx)
  );

  l2pg_perm_eval #(.PID_W(PID_W)) perm_i (
    .attr(attr_q[pg_idx]), .typ(acc_t'(req_type)), .sup_eff(sup_eff),
    .is_local(req_local), .pid(req_pid), .secure(req_secure),
    .sec_en(sec_en), .ok(perm_ok)
  );

  assign allow_c = pg_present && perm_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) attr_q[i] <= ATTR_RST;
    end else if (reg_we && (reg_addr < CLR_IDX)) begin
      attr_q[reg_addr[IDX_W-1:0]] <= reg_wdata;
    end
  end

  assign reg_rdata = (reg_addr < CLR_IDX) ? attr_q[reg_addr[IDX_W-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      ra_q <= 1'b0;
    end else begin
      rv_q <= req_valid;
      ra_q <= req_valid && allow_c;
    end
  end

  assign res_valid   = rv_q;
  assign res_allow   = ra_q;
  assign fault_pulse = rv_q && !ra_q;

  l2pg_fault_rec #(.ADDR_W(ADDR_W), .PID_W(PID_W)) rec_i (
    .clk(clk), .rst_n(rst_n),
    .cap(req_valid && !allow_c), .clr(rec_clr),
    .in_addr(req_addr), .in_pid(req_pid), .in_type(req_type),
    .in_sup(sup_eff), .in_secure(req_secure),
    .valid(flt_valid), .addr(flt_addr), .pid(flt_pid),
    .typ(flt_type), .sup(flt_sup), .secure(flt_secure)
  );

  // R9
  res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid));

  // R3
  absent_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pg_present) |=> (res_valid && !res_allow && fault_pulse));
endmodule

// File: tb/l2_page_guard_tb_top.sv
module l2_page_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_asym = 1'b0, sec_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [20:0] req_addr = '0;
  logic [3:0]  req_pid = '0;
  logic        req_local = 1'b0, req_cpu = 1'b0, req_sup = 1'b0, req_secure = 1'b0;
  logic [1:0]  req_type = '0;
  logic        res_valid, res_allow, fault_pulse;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [14:0] reg_wdata = '0;
  logic [14:0] reg_rdata;
  logic        flt_valid, flt_sup, flt_secure;
  logic [20:0] flt_addr;
  logic [3:0]  flt_pid;
  logic [1:0]  flt_type;

  int total = 0, bad = 0;
  logic [14:0] attr_m [64];
  bit          fv_m, fsup_m, fsec_m;
  logic [20:0] faddr_m;
  logic [3:0]  fpid_m;
  logic [1:0]  ftyp_m;
  bit          last_allow;

  always #2 clk = ~clk;

  l2_page_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_asym(cfg_asym), .sec_en(sec_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_pid(req_pid),
    .req_local(req_local), .req_cpu(req_cpu), .req_sup(req_sup),
    .req_secure(req_secure), .req_type(req_type),
    .res_valid(res_valid), .res_allow(res_allow), .fault_pulse(fault_pulse),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .flt_valid(flt_valid), .flt_addr(flt_addr),
    .flt_pid(flt_pid), .flt_type(flt_type), .flt_sup(flt_sup),
    .flt_secure(flt_secure)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic int map_idx(logic [20:0] a, bit asym);
    if (a < 21'h100000) return asym ? 32 + int'(a[19:15]) : int'(a[19:15]);
    if (asym && a < 21'h180000) return int'(a[18:14]);
    return -1;
  endfunction

  function automatic bit exp_allow(logic [20:0] a, logic [3:0] pid, bit loc, bit cpu,
                                   bit sup, bit sec, logic [1:0] typ);
    int idx = map_idx(a, cfg_asym);
    bit se;
    logic [14:0] at;
    if (idx < 0 || typ == 2'd3) return 1'b0;
    at = attr_m[idx];
    se = sup && (loc || cpu);
    if (!at[(se ? 3 : 0) + int'(typ)]) return 1'b0;
    if (loc) begin
      if (!at[6]) return 1'b0;
    end else if (pid < 6) begin
      if (!at[7 + int'(pid)]) return 1'b0;
    end else if (!at[13]) return 1'b0;
    if (sec_en && !sec && !at[14]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic step(input bit rv, input logic [20:0] a, input logic [3:0] pid,
                      input bit loc, input bit cpu, input bit sup, input bit sec,
                      input logic [1:0] typ, input bit we, input logic [6:0] wa,
                      input logic [14:0] wd);
    bit ea, deny, clr;
    @(negedge clk);
    req_valid = rv; req_addr = a; req_pid = pid; req_local = loc; req_cpu = cpu;
    req_sup = sup; req_secure = sec; req_type = typ;
    reg_we = we; reg_addr = wa; reg_wdata = wd;
    ea   = exp_allow(a, pid, loc, cpu, sup, sec, typ);
    deny = rv && !ea;
    clr  = we && (wa == 7'd64);
    @(posedge clk);
    #1;
    chk("R9 res_valid", res_valid, rv);
    if (rv) begin
      chk("R1 R2 R3 R4 R5 R6 R7 R8 R13 verdict", res_allow, ea);
      chk("R9 fault_pulse", fault_pulse, !ea);
    end else begin
      chk("R9 no pulse when idle", fault_pulse, 1'b0);
    end
    last_allow = res_allow;
    if (deny && (!fv_m || clr)) begin
      fv_m = 1'b1; faddr_m = a; fpid_m = pid; ftyp_m = typ;
      fsup_m = sup && (loc || cpu); fsec_m = sec;
    end else if (clr) begin
      fv_m = 1'b0;
    end
    if (we && wa < 7'd64) attr_m[wa] = wd;
    chk("R10 R11 flt_valid", flt_valid, fv_m);
    if (fv_m) begin
      chk("R10 flt_addr", flt_addr, faddr_m);
      chk("R10 flt_pid", flt_pid, fpid_m);
      chk("R10 flt_type", flt_type, ftyp_m);
      chk("R10 R7 flt_sup", flt_sup, fsup_m);
      chk("R10 flt_secure", flt_secure, fsec_m);
    end
    req_valid = 1'b0;
    reg_we = 1'b0;
  endtask

  task automatic rq(input logic [20:0] a, input logic [3:0] pid, input bit loc,
                    input bit cpu, input bit sup, input bit sec, input logic [1:0] typ);
    step(1'b1, a, pid, loc, cpu, sup, sec, typ, 1'b0, 7'd0, 15'd0);
  endtask

  task automatic wr(input logic [6:0] wa, input logic [14:0] wd);
    step(1'b0, 21'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, wa, wd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) attr_m[i] = 15'h0078;
    fv_m = 1'b0; fsup_m = 1'b0; fsec_m = 1'b0;
    faddr_m = '0; fpid_m = '0; ftyp_m = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12 reset state
    chk("R9 reset res_valid", res_valid, 1'b0);
    chk("R10 reset flt_valid", flt_valid, 1'b0);
    reg_addr = 7'd0;  #1 chk("R12 reset reg0", reg_rdata, 15'h0078);
    reg_addr = 7'd63; #1 chk("R12 reset reg63", reg_rdata, 15'h0078);

    // R4 R5 supervisor local read allowed, user read denied
    rq(21'h000100, 4'd0, 1, 1, 1, 1, 2'd0);
    chk("R4 R5 sup local read", last_allow, 1'b1);
    rq(21'h008000, 4'd0, 1, 1, 0, 0, 2'd1);
    chk("R4 user write denied", last_allow, 1'b0);
    chk("R10 first fault addr", flt_addr, 21'h008000);
    rq(21'h010000, 4'd2, 1, 1, 0, 0, 2'd2);
    chk("R10 later fault ignored", flt_addr, 21'h008000);

    // R11 clear, then clear with a deny in the same cycle
    wr(7'd64, 15'd0);
    chk("R11 clear", flt_valid, 1'b0);
    rq(21'h000000, 4'd1, 1, 1, 0, 1, 2'd0);
    step(1'b1, 21'h018000, 4'd5, 1, 1, 0, 1, 2'd0, 1'b1, 7'd64, 15'd0);
    chk("R11 capture wins over clear", flt_addr, 21'h018000);

    // R5 local bit
    wr(7'd1, 15'h0038);
    rq(21'h008000, 4'd0, 1, 1, 1, 1, 2'd0);
    chk("R5 local bit clear denies", last_allow, 1'b0);

    // R6 global by privilege ID
    wr(7'd2, 15'h0008 | 15'h0200);
    rq(21'h010000, 4'd2, 0, 1, 1, 1, 2'd0);
    chk("R6 aid2 allows", last_allow, 1'b1);
    rq(21'h010000, 4'd3, 0, 1, 1, 1, 2'd0);
    chk("R6 aid3 denied", last_allow, 1'b0);
    rq(21'h010000, 4'd7, 0, 1, 1, 1, 2'd0);
    chk("R6 other id denied", last_allow, 1'b0);
    wr(7'd2, 15'h0008 | 15'h2000);
    rq(21'h010000, 4'd9, 0, 1, 1, 1, 2'd0);
    chk("R6 other id bit allows", last_allow, 1'b1);

    // R7 non-CPU master treated as user
    rq(21'h010000, 4'd9, 0, 0, 1, 1, 2'd0);
    chk("R7 forced user mode", last_allow, 1'b0);

    // R8 secure gating
    sec_en = 1'b1;
    rq(21'h000000, 4'd0, 1, 1, 1, 0, 2'd0);
    chk("R8 non-secure denied", last_allow, 1'b0);
    wr(7'd0, 15'h4078);
    rq(21'h000000, 4'd0, 1, 1, 1, 0, 2'd0);
    chk("R8 open page allows", last_allow, 1'b1);
    sec_en = 1'b0;

    // R12 write and request in the same cycle use the old value
    step(1'b1, 21'h020000, 4'd0, 1, 1, 1, 1, 2'd0, 1'b1, 7'd4, 15'h0000);
    chk("R12 same-cycle old value", last_allow, 1'b1);
    rq(21'h020000, 4'd0, 1, 1, 1, 1, 2'd0);
    chk("R12 next-cycle new value", last_allow, 1'b0);
    reg_addr = 7'd4; #1 chk("R12 readback", reg_rdata, 15'h0000);

    // R1 R2 R3 layouts
    rq(21'h100000, 4'd0, 1, 1, 1, 1, 2'd0);
    chk("R1 R3 sym upper absent", last_allow, 1'b0);
    cfg_asym = 1'b1;
    wr(7'd32, 15'h0000);
    rq(21'h000000, 4'd0, 1, 1, 1, 1, 2'd0);
    chk("R2 start uses reg32", last_allow, 1'b0);
    wr(7'd5, 15'h0000);
    rq(21'h114000, 4'd0, 1, 1, 1, 1, 2'd0);
    chk("R2 small port page5", last_allow, 1'b0);
    rq(21'h110000, 4'd0, 1, 1, 1, 1, 2'd0);
    chk("R2 small port page4 wrote zero", last_allow, 1'b0);
    rq(21'h118000, 4'd0, 1, 1, 1, 1, 2'd0);
    chk("R2 small port page6 allows", last_allow, 1'b1);
    rq(21'h180000, 4'd0, 1, 1, 1, 1, 2'd0);
    chk("R2 R3 beyond absent", last_allow, 1'b0);

    // R13 invalid type
    rq(21'h118000, 4'd0, 1, 1, 1, 1, 2'd3);
    chk("R13 type3 denied", last_allow, 1'b0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit rv, we;
      logic [6:0] wa;
      logic [20:0] a;
      if (i % 500 == 0) begin
        cfg_asym = $urandom_range(0, 1);
        sec_en = $urandom_range(0, 1);
      end
      rv = $urandom_range(0, 9) < 7;
      we = $urandom_range(0, 9) < 3;
      wa = ($urandom_range(0, 9) == 0) ? 7'd64 : 7'($urandom_range(0, 63));
      a = ($urandom_range(0, 7) == 0) ? 21'($urandom) : 21'($urandom_range(0, 21'h17FFFF));
      step(rv, a, 4'($urandom_range(0, 8)), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 2'($urandom), we, wa, 15'($urandom) | 15'h0078);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule